// File: doc/BRIEF.md
# Bunch Clock Generator with Phase Alignment

This block derives a bunch-crossing enable from the machine clock by dividing it by sixteen. A 4-bit phase counter runs freely and wraps once per bunch period. The bunch boundary is the cycle in which the counter reads zero. An upstream decoder may send a phase-set command carrying a 4-bit code. That command reaches the counter after a fixed number of machine cycles, so its effect is exact to one machine period. The phase of the bunch enable with respect to the machine clock is therefore under the direct control of the command channel.

Enables are issued only inside a bunch train. A train-start command opens the train and clears the bunch index. A train-end command closes the train at the next boundary. Between trains the counter keeps its phase, but no enables are produced and the bunch index holds its value.

A phase change that would land inside a train is refused for the moment. It is kept until the train closes, and a sticky flag records that it happened. A separate probe input measures how many cycles have passed since the last boundary and compares that number with an expected latency. Any mismatch sets a second sticky flag.

There is no streaming data path: every pin is a plain control or status signal.

Top module: `bunch_clock_gen`

## Requirements
- R1: While in a train, `bunch_en` is a one-cycle pulse that repeats every 16 cycles. Two pulses are never less than 16 cycles apart.
- R2: After reset, `in_train` is 0. While `in_train` is 0, `bunch_en` stays 0.
- R3: The phase count increments by one per cycle modulo 16, and `bunch_en` can only be high when the count is 0. When `phase_set` is sampled at edge k and no train is running, the count holds `phase_code` right after edge k+CMD_DELAY (default 4).
- R4: `train_start` sampled at an edge sets `in_train` and clears `bunch_cnt` to 0 after that edge, including when a train is already running. The first pulse of the train carries index 0.
- R5: `bunch_cnt` increments after each `bunch_en` pulse. It holds its value while no train is running.
- R6: `train_end` takes effect at the next cycle whose count is 0, including the one in which it is sampled. In that cycle no pulse is issued, and `in_train` is 0 after it.
- R7: A phase-set that reaches the counter while `in_train` is 1 leaves the phase unchanged and sets the sticky `phase_err`. It is then applied at the first edge at which `in_train` is 0. If several arrive, the newest code wins.
- R8: `lat_probe` sampled at an edge compares the phase count at that edge (cycles since the last boundary) with `lat_expect`. `lat_done` is high for the next cycle, and a difference sets the sticky `lat_fault`.
- R9: Synchronous reset sets the phase count to 0 and clears `in_train`, `bunch_cnt`, `phase_err`, `lat_done`, `lat_fault` and any pending phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_set | input | 1 | Decoded phase-set command strobe |
| phase_code | input | 4 | Phase value loaded by the command |
| train_start | input | 1 | Train-start command strobe |
| train_end | input | 1 | Train-end command strobe |
| lat_probe | input | 1 | Latency measurement strobe |
| lat_expect | input | 4 | Expected cycles since the last boundary |
| bunch_en | output | 1 | Bunch clock enable pulse |
| bunch_cnt | output | CNT_W | Bunch index within the train |
| in_train | output | 1 | High while a train is open |
| phase_err | output | 1 | Sticky flag: a phase-set arrived during a train |
| lat_done | output | 1 | A latency comparison finished |
| lat_fault | output | 1 | Sticky flag: a measured latency differed from the expected value |

## Verification
Two functions can meet in one cycle. A deferred phase-set can be applied in the same cycle as a new train-start, right after a train closes. The bench provokes this in three steps: it sends a phase-set in the middle of a train, ends that train, and drives `train_start` in the first cycle in which `in_train` reads 0. The case is judged by where the first pulse of the new train falls. It must appear 9 cycles after the start command, which matches the deferred code 8; with the old phase it would appear 15 cycles after. The pulse must also carry index 0. A second meeting point is `train_end` sampled on a boundary cycle, which must suppress the pulse of that cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int unsigned PH_W  = 4;
  localparam int unsigned BURST = 1 << PH_W;

  typedef struct packed {
    logic            vld;
    logic [PH_W-1:0] code;
  } phase_cmd_t;
endpackage

// File: rtl/bcg_cmd_delay.sv
module bcg_cmd_delay
  import bcg_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  phase_cmd_t din,
  output phase_cmd_t dout
);
  phase_cmd_t stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/bcg_divider.sv
module bcg_divider
  import bcg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  phase_cmd_t      cmd,
  input  logic            in_train,
  output logic [PH_W-1:0] phase,
  output logic            tick,
  output logic            phase_err
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] pend_code_q;
  logic            pend_vld_q;
  logic            err_q;
  logic            load;
  logic [PH_W-1:0] load_val;

  always_comb begin
    load     = 1'b0;
    load_val = pend_code_q;
    if (!in_train) begin
      if (cmd.vld) begin
        load     = 1'b1;
        load_val = cmd.code;
      end else if (pend_vld_q) begin
        load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= '0;
      pend_code_q <= '0;
      pend_vld_q  <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      phase_q <= load ? load_val : phase_q + 1'b1;
      if (cmd.vld && in_train) begin
        pend_vld_q  <= 1'b1;
        pend_code_q <= cmd.code;
        err_q       <= 1'b1;
      end else if (load) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign phase     = phase_q;
  assign tick      = (phase_q == '0);
  assign phase_err = err_q;

  // R3
  free_run_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> phase_q == $past(phase_q) + 1'b1);

  // R7
  phase_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/bcg_train.sv
module bcg_train
  import bcg_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             train_start,
  input  logic             train_end,
  output logic             in_train,
  output logic             bunch_en,
  output logic [CNT_W-1:0] bunch_cnt
);
  localparam int unsigned SP_W = PH_W + 1;

  logic             in_q;
  logic             end_pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             end_req;
  logic [SP_W-1:0]  since_q;

  assign end_req  = end_pend_q | train_end;
  assign bunch_en = in_q & tick & ~end_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q       <= 1'b0;
      end_pend_q <= 1'b0;
      cnt_q      <= '0;
    end else if (train_start) begin
      in_q       <= 1'b1;
      end_pend_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      if (in_q && tick && end_req) begin
        in_q       <= 1'b0;
        end_pend_q <= 1'b0;
      end else if (in_q && train_end) begin
        end_pend_q <= 1'b1;
      end
      if (bunch_en) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) since_q <= SP_W'(BURST);
    else if (bunch_en) since_q <= SP_W'(1);
    else if (since_q < SP_W'(BURST)) since_q <= since_q + 1'b1;
  end

  assign in_train  = in_q;
  assign bunch_cnt = cnt_q;

  // R1
  en_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    bunch_en |-> since_q >= SP_W'(BURST));

  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    train_start |=> (in_q && cnt_q == '0));

  // R5
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_q && !train_start) |=> $stable(cnt_q));
endmodule

// File: rtl/bcg_lat_check.sv
module bcg_lat_check
  import bcg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            probe,
  input  logic [PH_W-1:0] expect_lat,
  input  logic [PH_W-1:0] phase,
  output logic            done,
  output logic            fault
);
  logic done_q;
  logic fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= probe;
      fault_q <= fault_q | (probe && (phase != expect_lat));
    end
  end

  assign done  = done_q;
  assign fault = fault_q;

  // R8
  probe_done_chk: assert property (@(posedge clk) disable iff (rst)
    probe |=> done_q);

  // R8
  lat_fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fault_q |=> fault_q);
endmodule

// File: rtl/bunch_clock_gen.sv
module bunch_clock_gen
  import bcg_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned CMD_DELAY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_set,
  input  logic [3:0]       phase_code,
  input  logic             train_start,
  input  logic             train_end,
  input  logic             lat_probe,
  input  logic [3:0]       lat_expect,
  output logic             bunch_en,
  output logic [CNT_W-1:0] bunch_cnt,
  output logic             in_train,
  output logic             phase_err,
  output logic             lat_done,
  output logic             lat_fault
);
  phase_cmd_t      raw_cmd;
  phase_cmd_t      dly_cmd;
  logic [PH_W-1:0] phase;
  logic            tick;

  assign raw_cmd = '{vld: phase_set, code: phase_code};

  bcg_cmd_delay #(.DEPTH(CMD_DELAY)) u_dly (
    .clk(clk), .rst(rst), .din(raw_cmd), .dout(dly_cmd)
  );

  bcg_divider u_div (
    .clk(clk), .rst(rst), .cmd(dly_cmd), .in_train(in_train),
    .phase(phase), .tick(tick), .phase_err(phase_err)
  );

  bcg_train #(.CNT_W(CNT_W)) u_train (
    .clk(clk), .rst(rst), .tick(tick), .train_start(train_start),
    .train_end(train_end), .in_train(in_train), .bunch_en(bunch_en),
    .bunch_cnt(bunch_cnt)
  );

  bcg_lat_check u_lat (
    .clk(clk), .rst(rst), .probe(lat_probe), .expect_lat(lat_expect),
    .phase(phase), .done(lat_done), .fault(lat_fault)
  );
endmodule

// File: tb/bunch_clock_gen_bench.sv
module bunch_clock_gen_bench;
  localparam int CW = 12;
  localparam int D  = 4;

  logic          clk = 0;
  logic          rst = 1;
  logic          phase_set = 0;
  logic [3:0]    phase_code = 0;
  logic          train_start = 0;
  logic          train_end = 0;
  logic          lat_probe = 0;
  logic [3:0]    lat_expect = 0;
  logic          bunch_en;
  logic [CW-1:0] bunch_cnt;
  logic          in_train;
  logic          phase_err;
  logic          lat_done;
  logic          lat_fault;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bunch_clock_gen #(.CNT_W(CW), .CMD_DELAY(D)) u_bunch_clock_gen (
    .clk(clk), .rst(rst), .phase_set(phase_set), .phase_code(phase_code),
    .train_start(train_start), .train_end(train_end), .lat_probe(lat_probe),
    .lat_expect(lat_expect), .bunch_en(bunch_en), .bunch_cnt(bunch_cnt),
    .in_train(in_train), .phase_err(phase_err), .lat_done(lat_done),
    .lat_fault(lat_fault)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_en(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bunch_en && n < 200);
  endtask

  task automatic t_reset;
    rst = 1;
    step(3);
    rst = 0;
    // R9: all state cleared after reset
    chk(in_train == 0, "R9 in_train", in_train, 0);
    chk(bunch_cnt == 0, "R9 bunch_cnt", bunch_cnt, 0);
    chk(phase_err == 0, "R9 phase_err", phase_err, 0);
    chk(lat_fault == 0 && lat_done == 0, "R9 lat flags", lat_fault, 0);
  endtask

  task automatic t_gap;
    int pulses = 0;
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (bunch_en) pulses++;
    end
    // R2: no pulse outside a train
    chk(pulses == 0, "R2 pulses outside train", pulses, 0);
  endtask

  task automatic t_align;
    int pulses = 0;
    int n;
    bit spacing_ok = 1;
    phase_code = 4'd12;
    phase_set = 1;
    step(1);
    phase_set = 0;
    step(D);
    train_start = 1;
    step(1);
    train_start = 0;
    // R4: train opened, index cleared
    chk(in_train == 1, "R4 in_train", in_train, 1);
    chk(bunch_cnt == 0, "R4 bunch_cnt", bunch_cnt, 0);
    chk(bunch_en == 0, "R3 early pulse", bunch_en, 0);
    step(2);
    chk(bunch_en == 0, "R3 early pulse", bunch_en, 0);
    step(1);
    // R3: code 12 -> boundary 4 cycles after load
    chk(bunch_en == 1, "R3 aligned pulse", bunch_en, 1);
    chk(bunch_cnt == 0, "R4 first index", bunch_cnt, 0);
    for (int k = 0; k < 4; k++) begin
      wait_en(n);
      pulses++;
      if (n != 16) spacing_ok = 0;
    end
    // R1: 16-cycle spacing
    chk(spacing_ok, "R1 spacing", n, 16);
    // R5: index advanced per pulse
    chk(bunch_cnt == 4, "R5 bunch_cnt", bunch_cnt, 4);
  endtask

  task automatic t_lat;
    // starts at a boundary cycle (phase 0)
    step(5);
    lat_probe = 1;
    lat_expect = 4'd5;
    step(1);
    lat_probe = 0;
    // R8: match
    chk(lat_done == 1, "R8 done", lat_done, 1);
    chk(lat_fault == 0, "R8 no fault", lat_fault, 0);
    lat_probe = 1;
    lat_expect = 4'd3;
    step(1);
    lat_probe = 0;
    // R8: mismatch (phase 6)
    chk(lat_fault == 1, "R8 fault", lat_fault, 1);
    step(1);
    chk(lat_fault == 1 && lat_done == 0, "R8 sticky", lat_done, 0);
  endtask

  task automatic t_end;
    int n;
    int held;
    int pulses = 0;
    wait_en(n);
    step(3);
    train_end = 1;
    step(1);
    train_end = 0;
    // R6: still open until the boundary
    chk(in_train == 1, "R6 held open", in_train, 1);
    step(12);
    chk(bunch_en == 0, "R6 boundary pulse suppressed", bunch_en, 0);
    step(1);
    chk(in_train == 0, "R6 closed", in_train, 0);
    held = bunch_cnt;
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (bunch_en) pulses++;
    end
    chk(pulses == 0, "R2 gap pulses", pulses, 0);
    // R5: index holds in gap
    chk(bunch_cnt == held, "R5 gap hold", bunch_cnt, held);
  endtask

  task automatic t_midphase;
    int n;
    train_start = 1;
    step(1);
    train_start = 0;
    wait_en(n);
    step(2);
    phase_code = 4'd8;
    phase_set = 1;
    step(1);
    phase_set = 0;
    step(D);
    // R7: flagged, phase unchanged
    chk(phase_err == 1, "R7 phase_err", phase_err, 1);
    wait_en(n);
    chk(n == 9, "R7 phase kept in train", n, 9);
    train_end = 1;
    step(1);
    train_end = 0;
    n = 0;
    while (in_train && n < 100) begin
      step(1);
      n++;
    end
    // deferred load and new train in the same cycle
    train_start = 1;
    step(1);
    train_start = 0;
    wait_en(n);
    chk(n == 8, "R7 deferred phase applied", n, 8);
    chk(bunch_cnt == 0, "R4 index on restart", bunch_cnt, 0);
    chk(phase_err == 1, "R7 sticky", phase_err, 1);
    wait_en(n);
    wait_en(n);
    chk(bunch_cnt == 2, "R5 count", bunch_cnt, 2);
    step(3);
    train_start = 1;
    step(1);
    train_start = 0;
    // R4: restart inside a running train
    chk(bunch_cnt == 0 && in_train == 1, "R4 restart", bunch_cnt, 0);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_gap();
    t_align();
    t_lat();
    t_end();
    t_midphase();
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule